// File: doc/BRIEF.md
# ECC Memory Path with Error Injection

This block sits between a simple host port and an on-chip array of 64-bit words. Each stored word carries eight check bits. On a host write the block computes single-error-correct, double-error-detect check bits from the data it was given. When software has armed injection, the block then inverts chosen data bits and chosen check bits before the word is stored. Stored contents therefore disagree with their check bits in a known way, and software can prove that its error handling works without waiting for a real fault.

On a host read the stored word is decoded. A single-bit fault is repaired in the returned data when correction is on. A fault that cannot be repaired is flagged and the raw data is returned. Each detected class raises a sticky status flag. A saturating counter tracks single-bit events and is compared against a programmable threshold. The address and syndrome of the first reported error are held for software.

A small word-addressed register port holds the controls, masks, error-class disables, status, counter and capture values. Word address map: 0 control, 1 data mask bits 31:0, 2 data mask bits 63:32, 3 check-bit mask, 4 class disable, 5 status, 6 counter/threshold, 7 capture address, 8 capture syndrome.

Top module: `ecc_mem_path`

## Requirements
- R1: While armed (control bit 2 = 1), a host write stores data XOR the 64-bit data mask (word 2 gives bits 63:32, word 1 gives bits 31:0) together with check bits computed from the unmodified data, so that a mask of 1 on a write of zero reads back, with correction off, as 1.
- R2: While armed, the check-bit mask (word 3, bits 7:0; bit i inverts check bit i, bit 7 being the overall parity) inverts stored check bits only, and a single inverted check bit reads back as the unmodified data with the single-bit flag set.
- R3: Writes made while not armed store clean words whatever the masks hold, and arming or disarming without a write leaves stored words unchanged.
- R4: A read accepted at a clock edge returns rdData with rdValid one cycle later than the following edge (two edges of latency), hostReady is low while a read is in flight, and a single-bit fault is corrected in rdData when control bit 1 (correction) is set.
- R5: With correction clear and checking on, a single-bit fault is reported but rdData carries the stored word unmodified.
- R6: A nonzero syndrome with even overall parity, or an odd-parity syndrome that names no bit, sets status bit 1 (multi-bit), leaves status bit 0 clear, and returns the stored word unmodified.
- R7: Word 6 holds the single-bit count in bits 7:0 (reset 0, saturating, writable) and the threshold in bits 15:8 (reset 1); every reported single-bit read adds one, and status bit 0 is set only when the new count is at least the threshold.
- R8: Class disable word 4 bit 0 suppresses single-bit reporting (no flag, no count, no capture) and bit 1 suppresses multi-bit reporting; correction still applies; with 0 every class is reported.
- R9: With control bit 0 (checking) clear, reads return the stored word unmodified and report nothing.
- R10: Status flags are sticky and cleared by writing 1 to them; the address (word 7) and the syndrome (word 8: bit 7 overall parity mismatch, bits 6:0 Hamming syndrome) of the first reported error are held until the next write to word 5.
- R11: Control resets to 3 (checking and correction on, disarmed), masks, disables and status reset to 0, and the mask words read back exactly the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host request valid |
| hostReady | output | 1 | Block can accept a request |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Word address |
| hostWdata | input | 64 | Write data |
| rdValid | output | 1 | Read data valid pulse |
| rdData | output | 64 | Read data |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |

## Verification
On every cycle the assertions check that the single-bit and multi-bit indications never coincide, that nothing is indicated when checking is off, that a multi-bit or uncorrected read returns exactly the stored word, and that read data appears only two edges after an accepted read. Only the bench scenarios can show that injection lands on the intended bits and only on armed writes, that the syndrome and address captured belong to the first error, that the counter and threshold interact as stated, and that the class disables and write-one-to-clear status behave through the register port.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int HAM_W  = CHK_W - 1;

  typedef struct packed {
    logic              eccOn;
    logic              fixOn;
    logic              injArm;
    logic [DATA_W-1:0] injData;
    logic [CHK_W-1:0]  injChk;
  } cfg_t;

  typedef struct packed {
    logic              rdDone;
    logic              sbe;
    logic              mbe;
    logic [CHK_W-1:0]  syndrome;
    logic [DATA_W-1:0] rawData;
  } evt_t;

  // Codeword position of data bit d: the d-th position that is not a power of two.
  function automatic logic [HAM_W-1:0] dataPos(input int d);
    logic [HAM_W-1:0] pos;
    int cnt;
    pos = '0;
    cnt = 0;
    for (int p = 1; p < (1 << HAM_W); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == d) pos = HAM_W'(p);
        cnt++;
      end
    end
    return pos;
  endfunction

  function automatic logic [CHK_W-1:0] eccEncode(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    logic [HAM_W-1:0] p;
    c = '0;
    for (int j = 0; j < DATA_W; j++) begin
      p = dataPos(j);
      for (int i = 0; i < HAM_W; i++) begin
        if (p[i]) c[i] = c[i] ^ d[j];
      end
    end
    c[CHK_W-1] = (^d) ^ (^c[HAM_W-1:0]);
    return c;
  endfunction
endpackage

// File: rtl/ecc_datapath.sv
module ecc_datapath
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_t              cfg,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output evt_t              evt,
  output logic [ADDR_W-1:0] evtAddr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WORD_W = DATA_W + CHK_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              rdPend;
  logic [DATA_W-1:0] rawData;
  logic [CHK_W-1:0]  rawChk;
  logic [ADDR_W-1:0] pendAddr;

  logic [HAM_W-1:0]  syn;
  logic              ovr;
  logic [DATA_W-1:0] flipMask;
  logic              chkHit, sbeRaw, mbeRaw;
  logic [DATA_W-1:0] outData;

  assign hostReady = !rdPend;

  always_ff @(posedge clk) begin
    if (hostValid && hostReady && hostWrite) begin
      mem[hostAddr] <= {
        hostWdata ^ (cfg.injArm ? cfg.injData : '0),
        (cfg.eccOn ? eccEncode(hostWdata) : '0) ^ (cfg.injArm ? cfg.injChk : '0)
      };
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPend   <= 1'b0;
      rawData  <= '0;
      rawChk   <= '0;
      pendAddr <= '0;
      rdValid  <= 1'b0;
      rdData   <= '0;
    end else begin
      rdPend  <= hostValid && hostReady && !hostWrite;
      rdValid <= rdPend;
      if (hostValid && hostReady && !hostWrite) begin
        {rawData, rawChk} <= mem[hostAddr];
        pendAddr          <= hostAddr;
      end
      if (rdPend) rdData <= outData;
    end
  end

  always_comb begin
    syn = eccEncode(rawData)[HAM_W-1:0] ^ rawChk[HAM_W-1:0];
    ovr = (^rawData) ^ (^rawChk);
    for (int d = 0; d < DATA_W; d++) flipMask[d] = (syn == dataPos(d));
    chkHit = (syn & (syn - 1'b1)) == '0;
    sbeRaw = cfg.eccOn && ovr && (chkHit || (|flipMask));
    mbeRaw = cfg.eccOn && ((syn != '0) || ovr) && !sbeRaw;
    outData = (sbeRaw && cfg.fixOn) ? (rawData ^ flipMask) : rawData;
  end

  always_comb begin
    evt.rdDone   = rdPend;
    evt.sbe      = rdPend && sbeRaw;
    evt.mbe      = rdPend && mbeRaw;
    evt.syndrome = {ovr, syn};
    evt.rawData  = rawData;
    evtAddr      = pendAddr;
  end
endmodule

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  evt_t              evt,
  input  logic [ADDR_W-1:0] evtAddr,
  output cfg_t              cfg
);
  localparam logic [3:0] A_CTRL = 4'd0, A_INJLO = 4'd1, A_INJHI = 4'd2, A_INJCHK = 4'd3,
                         A_DIS = 4'd4, A_STS = 4'd5, A_CNT = 4'd6, A_CADDR = 4'd7, A_CSYN = 4'd8;

  logic [2:0]        ctrlReg;
  logic [31:0]       injLo, injHi;
  logic [CHK_W-1:0]  injChk;
  logic [1:0]        disReg, stsReg;
  logic [CNT_W-1:0]  sbeCount, sbeThr, countNext;
  logic [ADDR_W-1:0] captAddr;
  logic [CHK_W-1:0]  captSyn;
  logic              captHeld;
  logic              sbeRep, mbeRep;

  assign sbeRep    = evt.sbe && !disReg[0];
  assign mbeRep    = evt.mbe && !disReg[1];
  assign countNext = (&sbeCount) ? sbeCount : sbeCount + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= 3'b011;
      injLo    <= '0;
      injHi    <= '0;
      injChk   <= '0;
      disReg   <= '0;
      stsReg   <= '0;
      sbeCount <= '0;
      sbeThr   <= CNT_W'(1);
      captAddr <= '0;
      captSyn  <= '0;
      captHeld <= 1'b0;
    end else begin
      if (regWe) begin
        case (regAddr)
          A_CTRL:   ctrlReg <= regWdata[2:0];
          A_INJLO:  injLo   <= regWdata;
          A_INJHI:  injHi   <= regWdata;
          A_INJCHK: injChk  <= regWdata[CHK_W-1:0];
          A_DIS:    disReg  <= regWdata[1:0];
          default:  ;
        endcase
      end
      // Status: write-one-to-clear, a new event in the same cycle wins
      stsReg <= (stsReg & ~((regWe && regAddr == A_STS) ? regWdata[1:0] : 2'b00))
              | {mbeRep, sbeRep && (countNext >= sbeThr)};
      if (regWe && regAddr == A_CNT) begin
        sbeCount <= regWdata[CNT_W-1:0];
        sbeThr   <= regWdata[CNT_W+7:8];
      end else if (sbeRep) begin
        sbeCount <= countNext;
      end
      if ((sbeRep || mbeRep) && !captHeld) begin
        captAddr <= evtAddr;
        captSyn  <= evt.syndrome;
        captHeld <= 1'b1;
      end else if (regWe && regAddr == A_STS) begin
        captHeld <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CTRL:   regRdata[2:0]       = ctrlReg;
      A_INJLO:  regRdata            = injLo;
      A_INJHI:  regRdata            = injHi;
      A_INJCHK: regRdata[CHK_W-1:0] = injChk;
      A_DIS:    regRdata[1:0]       = disReg;
      A_STS:    regRdata[1:0]       = stsReg;
      A_CNT:    regRdata[CNT_W+7:0] = {sbeThr, sbeCount};
      A_CADDR:  regRdata[ADDR_W-1:0] = captAddr;
      A_CSYN:   regRdata[CHK_W-1:0] = captSyn;
      default:  regRdata = '0;
    endcase
  end

  always_comb begin
    cfg.eccOn   = ctrlReg[0];
    cfg.fixOn   = ctrlReg[1];
    cfg.injArm  = ctrlReg[2];
    cfg.injData = {injHi, injLo};
    cfg.injChk  = injChk;
  end
endmodule

// File: rtl/ecc_mem_path.sv
module ecc_mem_path
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  output logic              hostReady,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [63:0]       hostWdata,
  output logic              rdValid,
  output logic [63:0]       rdData,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata
);
  cfg_t              cfg;
  evt_t              evt;
  logic [ADDR_W-1:0] evtAddr;

  ecc_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .evt(evt), .evtAddr(evtAddr), .cfg(cfg)
  );

  ecc_datapath #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostReady(hostReady), .rdValid(rdValid),
    .rdData(rdData), .evt(evt), .evtAddr(evtAddr)
  );
endmodule

// File: rtl/ecc_mem_path_chk.sv
module ecc_mem_path_chk
  import ecc_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        hostValid,
  input logic        hostReady,
  input logic        hostWrite,
  input logic        rdValid,
  input logic [63:0] rdData,
  input cfg_t        cfg,
  input evt_t        evt
);
  // R6: one class at a time
  p_class_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(evt.sbe && evt.mbe));

  // R6: multi-bit read hands back the stored word
  p_mbe_raw_r6: assert property (@(posedge clk) disable iff (!rstN)
    (evt.rdDone && evt.mbe) |=> (rdValid && rdData == $past(evt.rawData)));

  // R5: no correction when correction is off
  p_nofix_raw_r5: assert property (@(posedge clk) disable iff (!rstN)
    (evt.rdDone && !cfg.fixOn) |=> (rdData == $past(evt.rawData)));

  // R9: nothing reported with checking off
  p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (evt.rdDone && !cfg.eccOn) |-> (!evt.sbe && !evt.mbe));

  // R4: read data only two edges after an accepted read
  p_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(hostValid && hostReady && !hostWrite, 2));
endmodule

bind ecc_mem_path ecc_mem_path_chk i_chk (
  .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostReady(hostReady),
  .hostWrite(hostWrite), .rdValid(rdValid), .rdData(rdData), .cfg(cfg), .evt(evt)
);

// File: tb/test_ecc_mem_path.sv
module test_ecc_mem_path;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0;
  logic        hostWrite = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic [63:0] hostWdata = '0;
  logic        hostReady, rdValid;
  logic [63:0] rdData;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  ecc_mem_path i_ecc_mem_path (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostReady(hostReady),
    .hostWrite(hostWrite), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .rdValid(rdValid), .rdData(rdData), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic hostWr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    hostValid = 1'b1; hostWrite = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostValid = 1'b0; hostWrite = 1'b0;
  endtask

  task automatic hostRd(input logic [3:0] a, output logic [63:0] d, output logic rdy);
    @(negedge clk);
    hostValid = 1'b1; hostWrite = 1'b0; hostAddr = a;
    @(negedge clk);
    hostValid = 1'b0;
    rdy = hostReady;
    @(negedge clk);
    check("R4 rdValid", 64'(rdValid), 64'd1);
    d = rdData;
  endtask

  task automatic clearSts();
    regWr(4'd5, 32'h3);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    regRd(4'd0, r); check("R11 ctrl reset", 64'(r), 64'd3);
    regRd(4'd1, r); check("R11 mask lo reset", 64'(r), 64'd0);
    regRd(4'd5, r); check("R11 status reset", 64'(r), 64'd0);
    regRd(4'd6, r); check("R7 count/threshold reset", 64'(r), 64'h100);
    check("R4 ready idle", 64'(hostReady), 64'd1);
  endtask

  task automatic t_inject_lsb();
    logic [31:0] r; logic [63:0] d; logic rdy;
    regWr(4'd1, 32'h1);
    regRd(4'd1, r); check("R11 mask lo readback", 64'(r), 64'h1);
    regWr(4'd2, 32'hA5A5_0F0F);
    regRd(4'd2, r); check("R11 mask hi readback", 64'(r), 64'hA5A5_0F0F);
    regWr(4'd2, 32'h0);
    regWr(4'd0, 32'h7);
    hostWr(4'd2, 64'h0);
    regWr(4'd0, 32'h3);
    hostRd(4'd2, d, rdy);
    check("R4 ready low in flight", 64'(rdy), 64'd0);
    check("R4 corrected data", d, 64'h0);
    regRd(4'd5, r); check("R7 sbe flag at threshold 1", 64'(r), 64'h1);
    regRd(4'd6, r); check("R7 count 1", 64'(r[7:0]), 64'd1);
    regRd(4'd7, r); check("R10 capture addr", 64'(r), 64'd2);
    regRd(4'd8, r); check("R10 capture syndrome", 64'(r), 64'h83);
    regWr(4'd0, 32'h1);
    hostRd(4'd2, d, rdy);
    check("R1 R5 raw stored lsb", d, 64'h1);
    regWr(4'd0, 32'h3);
  endtask

  task automatic t_sticky();
    logic [31:0] r;
    regWr(4'd5, 32'h0);
    regRd(4'd5, r); check("R10 write 0 keeps flag", 64'(r), 64'h1);
    clearSts();
    regRd(4'd5, r); check("R10 write 1 clears", 64'(r), 64'h0);
  endtask

  task automatic t_chk_inject();
    logic [31:0] r; logic [63:0] d; logic rdy;
    regWr(4'd1, 32'h0);
    regWr(4'd3, 32'h01);
    regWr(4'd0, 32'h7);
    hostWr(4'd5, 64'hDEAD_BEEF_0123_4567);
    regWr(4'd0, 32'h3);
    regWr(4'd3, 32'h0);
    hostRd(4'd5, d, rdy);
    check("R2 data intact", d, 64'hDEAD_BEEF_0123_4567);
    regRd(4'd5, r); check("R2 sbe flag", 64'(r), 64'h1);
    regRd(4'd7, r); check("R10 new capture addr", 64'(r), 64'd5);
    regRd(4'd8, r); check("R2 R10 check-bit syndrome", 64'(r), 64'h81);
    clearSts();
  endtask

  task automatic t_disarmed();
    logic [31:0] r; logic [63:0] d; logic rdy;
    regWr(4'd1, 32'hFFFF_FFFF);
    hostWr(4'd6, 64'h1234_5678_9ABC_DEF0);
    regWr(4'd0, 32'h7);
    regWr(4'd0, 32'h3);
    regWr(4'd0, 32'h1);
    hostRd(4'd6, d, rdy);
    check("R3 disarmed write clean", d, 64'h1234_5678_9ABC_DEF0);
    regRd(4'd5, r); check("R3 no flag", 64'(r), 64'h0);
    regWr(4'd0, 32'h3);
  endtask

  task automatic t_multi();
    logic [31:0] r; logic [63:0] d; logic rdy;
    regWr(4'd6, 32'h0100);
    regWr(4'd1, 32'h3);
    regWr(4'd0, 32'h7);
    hostWr(4'd7, 64'h0);
    regWr(4'd0, 32'h3);
    hostRd(4'd7, d, rdy);
    check("R6 raw returned", d, 64'h3);
    regRd(4'd5, r); check("R6 mbe flag only", 64'(r), 64'h2);
    regRd(4'd6, r); check("R6 count unchanged", 64'(r[7:0]), 64'd0);
    clearSts();
  endtask

  task automatic t_disable();
    logic [31:0] r; logic [63:0] d; logic rdy;
    regWr(4'd4, 32'h1);
    hostRd(4'd2, d, rdy);
    check("R8 still corrected", d, 64'h0);
    regRd(4'd5, r); check("R8 sbe suppressed", 64'(r), 64'h0);
    regRd(4'd6, r); check("R8 count suppressed", 64'(r[7:0]), 64'd0);
    regWr(4'd4, 32'h2);
    hostRd(4'd7, d, rdy);
    regRd(4'd5, r); check("R8 mbe suppressed", 64'(r), 64'h0);
    regWr(4'd4, 32'h0);
  endtask

  task automatic t_ecc_off();
    logic [31:0] r; logic [63:0] d; logic rdy;
    regWr(4'd0, 32'h2);
    hostRd(4'd7, d, rdy);
    check("R9 raw with checking off", d, 64'h3);
    hostRd(4'd2, d, rdy);
    check("R9 no correction", d, 64'h1);
    regRd(4'd5, r); check("R9 no report", 64'(r), 64'h0);
    regWr(4'd0, 32'h3);
  endtask

  task automatic t_threshold();
    logic [31:0] r; logic [63:0] d; logic rdy;
    clearSts();
    regWr(4'd6, 32'h0300);
    hostRd(4'd2, d, rdy);
    hostRd(4'd2, d, rdy);
    regRd(4'd5, r); check("R7 below threshold", 64'(r), 64'h0);
    regRd(4'd6, r); check("R7 count 2", 64'(r), 64'h0302);
    hostRd(4'd2, d, rdy);
    regRd(4'd5, r); check("R7 threshold reached", 64'(r), 64'h1);
    regWr(4'd6, 32'h01FF);
    hostRd(4'd2, d, rdy);
    regRd(4'd6, r); check("R7 count saturates", 64'(r), 64'h01FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_inject_lsb();
    t_sticky();
    t_chk_inject();
    t_disarmed();
    t_multi();
    t_disable();
    t_ecc_off();
    t_threshold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule